// File: doc/BRIEF.md
# Toggle-Handshake Word Crossing

This block carries a multi-bit word from a source clock domain into a destination clock domain that has no fixed phase or frequency relationship to the source. Each transfer starts with a launch event in the source domain. On that event the word is frozen in a source-side holding register, and a source-side toggle flop changes state.

Only the toggle level crosses the boundary. It passes through a short chain of destination flops. An XOR between the last chain stage and a one-cycle-delayed copy of it recovers a single-cycle event. That event samples the frozen word into a destination register and raises a one-cycle valid flag. No FIFO is involved.

The integrator must space launches so that each word is sampled on the far side before the holding register is overwritten. Launches must be at least two destination periods apart, and in practice a few more. For a generator that fires every Rate+1 source cycles, Rate must be greater than twice the source-to-destination frequency ratio, rounded up, and never below 1. The `TRIG` parameter selects how a launch is recognised. With `TRIG_STROBE` (0), each source cycle with `launch_i` high is one launch. With `TRIG_LEVEL` (1), `launch_i` is a level flag and only its 0-to-1 transition launches.

Top module: `xwb_bridge`

## Requirements
- R1: On a launch, the holding register takes `word_i` at that same source clock edge.
- R2: The source toggle changes state exactly once per launch and holds its value otherwise.
- R3: The toggle reaches the destination only through a chain of `SYNC_N` destination flops (default 2), each stage copying the previous one on every destination edge.
- R4: `valid_o` is high for exactly one destination cycle per launch and is never high on two consecutive destination cycles.
- R5: `word_o` changes only in the cycle in which `valid_o` is high. It then holds the word captured at the launch that produced that `valid_o`.
- R6: When launches are spaced far enough apart, every launched word appears at the destination exactly once and in launch order. This holds with a fast destination clock and with a slow one.
- R7: While `rst_src` and `rst_dst` are high, `valid_o` is 0 and `word_o` is 0.
- R8: With `TRIG_LEVEL`, only a 0-to-1 change of `launch_i` launches a transfer. Holding `launch_i` high, changing `word_i` while it is high, or dropping it launches nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source domain clock |
| rst_src | input | 1 | Source domain synchronous reset, active high |
| clk_dst | input | 1 | Destination domain clock |
| rst_dst | input | 1 | Destination domain synchronous reset, active high |
| launch_i | input | 1 | Launch strobe (`TRIG_STROBE`) or level valid flag (`TRIG_LEVEL`) |
| word_i | input | W | Word to transfer, sampled on a launch |
| word_o | output | W | Last word delivered to the destination |
| valid_o | output | 1 | One-cycle flag marking a newly delivered word |

## Verification
The bench drives random words at the minimum safe launch spacing. It does this first with a destination clock much faster than the source and then with one much slower. A design that missed a toggle would drop words, and one that re-detected an edge would duplicate them. Either shows up as a length or order mismatch against the bench's queue of launched words. A design that sampled the holding register at the wrong time would deliver the previous or the next word.

In the level-triggered variant, the bench holds the flag high for many cycles and changes the word while it is high. A design that treated the level as a strobe would then deliver a stream of words instead of the single word present at the rising edge. The bench also checks that no word or flag leaks out during reset.

// File: rtl/xwb_pkg.sv
package xwb_pkg;
  typedef enum logic {
    TRIG_STROBE = 1'b0,
    TRIG_LEVEL  = 1'b1
  } xwb_trig_e;
endpackage

// File: rtl/xwb_launch.sv
module xwb_launch #(
  parameter int                 W    = 16,
  parameter xwb_pkg::xwb_trig_e TRIG = xwb_pkg::TRIG_STROBE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] hold_o,
  output logic         tog_o
);
  logic fire;

  generate
    if (TRIG == xwb_pkg::TRIG_LEVEL) begin : g_level
      logic lvl_q;
      always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= go_i;
      end
      assign fire = go_i & ~lvl_q;

      // R8: a flag that was already high launches nothing
      p_rise_only_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && go_i && $past(go_i)) |-> !fire);
    end else begin : g_strobe
      assign fire = go_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o <= '0;
      tog_o  <= 1'b0;
    end else if (fire) begin
      hold_o <= word_i;
      tog_o  <= ~tog_o;
    end
  end

  p_hold_load_r1: assert property (@(posedge clk) disable iff (rst)
    fire |=> (hold_o == $past(word_i)));
  p_tog_flip_r2: assert property (@(posedge clk) disable iff (rst)
    fire |=> (tog_o != $past(tog_o)));
  p_tog_still_r2: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(tog_o));
endmodule

// File: rtl/xwb_tsync.sv
module xwb_tsync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_i,
  output logic pulse_o
);
  localparam int LAST = SYNC_N - 1;

  logic [SYNC_N-1:0] st_q;
  logic              dly_q;

  always_ff @(posedge clk) begin
    if (rst) st_q[0] <= 1'b0;
    else     st_q[0] <= tog_i;
  end

  generate
    for (genvar k = 1; k < SYNC_N; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st_q[k] <= 1'b0;
        else     st_q[k] <= st_q[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dly_q <= 1'b0;
    else     dly_q <= st_q[LAST];
  end

  assign pulse_o = st_q[LAST] ^ dly_q;

  // R3: a difference between the first and last stage drains forward
  p_chain_move_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q[0] != st_q[LAST]) |=> (st_q[LAST] == $past(st_q[LAST-1])));
  // R4: the recovered event never lasts two cycles
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/xwb_capture.sv
module xwb_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= take_i;
      if (take_i) word_o <= data_i;
    end
  end

  p_valid_once_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  p_word_moves_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_o) |-> valid_o);
endmodule

// File: rtl/xwb_bridge.sv
module xwb_bridge #(
  parameter int                 W      = 16,
  parameter int                 SYNC_N = 2,
  parameter xwb_pkg::xwb_trig_e TRIG   = xwb_pkg::TRIG_STROBE
) (
  input  logic         clk_src,
  input  logic         rst_src,
  input  logic         clk_dst,
  input  logic         rst_dst,
  input  logic         launch_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  logic [W-1:0] hold_w;
  logic         tog_w;
  logic         pulse_w;

  xwb_launch #(.W(W), .TRIG(TRIG)) launch_i0 (
    .clk(clk_src), .rst(rst_src), .go_i(launch_i), .word_i(word_i),
    .hold_o(hold_w), .tog_o(tog_w)
  );

  xwb_tsync #(.SYNC_N(SYNC_N)) tsync_i0 (
    .clk(clk_dst), .rst(rst_dst), .tog_i(tog_w), .pulse_o(pulse_w)
  );

  xwb_capture #(.W(W)) capture_i0 (
    .clk(clk_dst), .rst(rst_dst), .take_i(pulse_w), .data_i(hold_w),
    .word_o(word_o), .valid_o(valid_o)
  );

  // R4: every delivered flag follows a recovered event one edge earlier
  p_valid_src_r4: assert property (@(posedge clk_dst) disable iff (rst_dst)
    valid_o |-> $past(pulse_w));
endmodule

// File: tb/xwb_bridge_tb.sv
`timescale 1ns/1ps
module xwb_bridge_tb_top;
  localparam int W = 16;

  logic clk_src = 1'b0, clk_dst = 1'b0;
  logic rst_src = 1'b1, rst_dst = 1'b1;
  real  half_d  = 1.85;

  logic         stb = 1'b0, lvl = 1'b0;
  logic [W-1:0] stb_word = '0, lvl_word = '0;
  logic [W-1:0] q_word, l_word;
  logic         q_valid, l_valid;

  int checks = 0, fails = 0;
  logic [W-1:0] expq[$];
  int  lvl_seen = 0;
  logic [W-1:0] lvl_last = '0;
  logic q_prev = 1'b0, l_prev = 1'b0;

  always #5 clk_src = ~clk_src;
  always #(half_d) clk_dst = ~clk_dst;

  xwb_bridge #(.W(W), .TRIG(xwb_pkg::TRIG_STROBE)) dut_i (
    .clk_src(clk_src), .rst_src(rst_src), .clk_dst(clk_dst), .rst_dst(rst_dst),
    .launch_i(stb), .word_i(stb_word), .word_o(q_word), .valid_o(q_valid));

  xwb_bridge #(.W(W), .TRIG(xwb_pkg::TRIG_LEVEL)) dut_lvl_i (
    .clk_src(clk_src), .rst_src(rst_src), .clk_dst(clk_dst), .rst_dst(rst_dst),
    .launch_i(lvl), .word_i(lvl_word), .word_o(l_word), .valid_o(l_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int min_gap(input real hd);
    return $rtoi((12.0 * hd) / 10.0) + 3;
  endfunction

  // destination monitor, sampled on the falling edge
  always @(negedge clk_dst) begin
    if (!rst_dst) begin
      if (q_valid) begin
        chk(!q_prev, "R4", 1, 0);
        if (expq.size() == 0) chk(1'b0, "R6 extra word", int'(q_word), 0);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          chk(q_word == e, "R6/R5", int'(q_word), int'(e));
        end
      end
      if (l_valid) begin
        chk(!l_prev, "R4 level", 1, 0);
        lvl_seen++;
        lvl_last = l_word;
      end
    end
    q_prev = q_valid;
    l_prev = l_valid;
  end

  task automatic launch_word(input logic [W-1:0] w, input int gap);
    @(negedge clk_src);
    stb = 1'b1; stb_word = w; expq.push_back(w);
    @(negedge clk_src);
    stb = 1'b0; stb_word = $urandom;
    repeat (gap) @(negedge clk_src);
  endtask

  task automatic run_phase(input int n, input string tag);
    int g = min_gap(half_d);
    launch_word('0, g);
    launch_word('1, g);
    for (int i = 0; i < n; i++) launch_word(W'($urandom), g + int'($urandom_range(0, 4)));
    repeat (40) @(negedge clk_src);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk_src);
    stb = 1'b1; stb_word = 16'hBEEF; lvl = 1'b1; lvl_word = 16'hCAFE;
    repeat (3) @(negedge clk_src);
    chk(q_valid == 1'b0 && l_valid == 1'b0, "R7 valid", int'(q_valid | l_valid), 0);
    chk(q_word == '0, "R7 word", int'(q_word), 0);
    chk(l_word == '0, "R7 level word", int'(l_word), 0);
    stb = 1'b0; lvl = 1'b0;
    @(negedge clk_src);
    rst_src = 1'b0; rst_dst = 1'b0;
    repeat (5) @(negedge clk_src);
    chk(q_valid == 1'b0 && q_word == '0, "R7 after release", int'(q_word), 0);

    // R6 fast destination
    half_d = 1.85;
    run_phase(40, "R6 fast dst drained");
    // R6 slow destination
    half_d = 11.5;
    repeat (4) @(negedge clk_src);
    run_phase(25, "R6 slow dst drained");

    // R8 level trigger: hold high, alter word, drop
    half_d = 3.3;
    repeat (10) @(negedge clk_src);
    lvl_seen = 0;
    lvl_word = 16'h1357; lvl = 1'b1;
    repeat (5) @(negedge clk_src);
    lvl_word = 16'h2468;
    repeat (30) @(negedge clk_src);
    lvl = 1'b0;
    repeat (30) @(negedge clk_src);
    chk(lvl_seen == 1, "R8 one launch", lvl_seen, 1);
    chk(lvl_last == 16'h1357, "R8 word at rise", int'(lvl_last), 16'h1357);
    chk(l_word == 16'h1357, "R8 word kept", int'(l_word), 16'h1357);
    lvl_word = 16'h0F0F; lvl = 1'b1;
    repeat (30) @(negedge clk_src);
    chk(lvl_seen == 2 && l_word == 16'h0F0F, "R8 second rise", int'(l_word), 16'h0F0F);
    lvl = 1'b0;
    repeat (20) @(negedge clk_src);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule